// File: doc/BRIEF.md
# Miss Status Holding Register File

This block keeps track of cache misses that are still waiting for memory, so that a lockup-free data cache can go on serving the processor while those misses are in flight. Each processor miss is presented as a lookup carrying the block address, the cache line that will receive the block, and the destination register of the load. The lookup is compared against every busy entry in the same cycle.

A lookup to a block with nothing pending takes a free entry and produces exactly one memory request. A lookup to a block that is already pending is merged into the existing entry as an extra target, and no new request is sent. When neither path has room, the lookup is refused with a stall.

Memory requests leave on a valid/ready handshake, and the entry index travels with each request as its tag. When a fill comes back carrying that tag, the block replays every recorded target, one completion per cycle, and then frees the entry.

Top module: `mshr_file`

## Requirements
- R1: After reset every entry is free, memReqValid and cmplValid are low, fillReady is high, and lookupStall is low.
- R2: A lookup whose block address matches no busy entry is accepted when an entry is free. It takes the lowest-numbered free entry. In the next cycle a memory request appears with memReqTag equal to that index and memReqAddr equal to the block address.
- R3: A lookup whose block address matches a busy entry is accepted as an extra target of that entry, as long as the entry holds fewer than 4 targets. It never causes another memory request.
- R4: A lookup to an unmatched block while all 4 entries are busy is refused with lookupStall high, and it allocates nothing.
- R5: A lookup that matches an entry already holding 4 targets is refused with lookupStall high, and it adds no target.
- R6: While several entries wait to send a request, the lowest-numbered one is offered. Once offered, tag and address stay unchanged until memReqReady is seen. Each entry sends exactly one request.
- R7: A fill accepted with fillValid and fillReady for tag t produces, from the next cycle on, one completion per cycle (cmplValid high, cmplTag t). The completions follow target arrival order. Each carries the cache line recorded by the primary miss and the register of that target. After the last completion the entry is free, and a later lookup to that block is a primary miss again.
- R8: fillReady stays low while any entry is replaying completions.
- R9: A lookup to a block whose entry is receiving its fill in the same cycle, or is replaying, is appended as a target. It is replayed before the entry is freed.
- R10: Lookups keep being accepted while earlier misses are outstanding, unless R4 or R5 applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lookupValid | input | 1 | A processor miss is presented |
| lookupAddr | input | ADDR_W | Block address of the miss |
| lookupLine | input | LINE_W | Cache line that will receive the block |
| lookupReg | input | REG_W | Destination register of the access |
| lookupStall | output | 1 | Lookup refused this cycle |
| memReqValid | output | 1 | Fill request offered to memory |
| memReqReady | input | 1 | Memory takes the request |
| memReqAddr | output | ADDR_W | Block address requested |
| memReqTag | output | IDX_W | Entry index carried as request tag |
| fillValid | input | 1 | Fill data has returned |
| fillReady | output | 1 | Block can take a fill this cycle |
| fillTag | input | IDX_W | Entry index of the returning fill |
| cmplValid | output | 1 | A completion record is emitted |
| cmplTag | output | IDX_W | Entry being completed |
| cmplLine | output | LINE_W | Cache destination line of the block |
| cmplReg | output | REG_W | Destination register for this completion |

## Verification
The bench builds the block with 4 entries, 4 target slots, 26-bit block addresses, 10-bit line numbers and 6-bit register numbers. At this size a sweep can fill every entry and most target slots, and then push one entry to its slot limit while the file as a whole is full. The bench also drains fills out of tag order. It covers a fill that coincides with a matching lookup and a lookup that lands in the middle of a replay. All expected registers and lines follow arithmetically from the entry and slot numbers.

// File: rtl/mshr_pkg.sv
package mshr_pkg;
  localparam int unsigned NUM_ENTRIES = 4;
  localparam int unsigned NUM_TARGETS = 4;
  localparam int unsigned IDX_W  = $clog2(NUM_ENTRIES);
  localparam int unsigned SLOT_W = $clog2(NUM_TARGETS);
  localparam int unsigned CNT_W  = $clog2(NUM_TARGETS + 1);

  typedef enum logic [1:0] {
    EntFree     = 2'd0,
    EntNeedReq  = 2'd1,
    EntWaitFill = 2'd2,
    EntDrain    = 2'd3
  } entState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic              alloc;
    logic [IDX_W-1:0]  allocIdx;
    logic              append;
    logic [IDX_W-1:0]  appendIdx;
    logic [SLOT_W-1:0] appendSlot;
    logic [IDX_W-1:0]  reqIdx;
    logic [IDX_W-1:0]  drainIdx;
    logic [SLOT_W-1:0] drainSlot;
  } ctrlStrobe_t;
endpackage

// File: rtl/mshr_data.sv
module mshr_data
  import mshr_pkg::*;
#(
  parameter int unsigned ADDR_W = 26,
  parameter int unsigned LINE_W = 10,
  parameter int unsigned REG_W  = 6
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ctrlStrobe_t            strobe,
  input  logic [NUM_ENTRIES-1:0] entryBusy,
  input  logic [ADDR_W-1:0]      lookupAddr,
  input  logic [LINE_W-1:0]      lookupLine,
  input  logic [REG_W-1:0]       lookupReg,
  output logic [NUM_ENTRIES-1:0] matchVec,
  output logic [ADDR_W-1:0]      reqAddr,
  output logic [LINE_W-1:0]      cmplLine,
  output logic [REG_W-1:0]       cmplReg
);
  logic [ADDR_W-1:0] blkAddr [NUM_ENTRIES];
  logic [LINE_W-1:0] lineTab [NUM_ENTRIES];
  logic [REG_W-1:0]  regTab  [NUM_ENTRIES][NUM_TARGETS];

  always_ff @(posedge clk) begin
    if (strobe.alloc) begin
      blkAddr[strobe.allocIdx]   <= lookupAddr;
      lineTab[strobe.allocIdx]   <= lookupLine;
      regTab[strobe.allocIdx][0] <= lookupReg;
    end
    if (strobe.append)
      regTab[strobe.appendIdx][strobe.appendSlot] <= lookupReg;
  end

  // parallel compare against every busy entry
  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : gCmp
    assign matchVec[g] = entryBusy[g] && (blkAddr[g] == lookupAddr);
  end

  assign reqAddr  = blkAddr[strobe.reqIdx];
  assign cmplLine = lineTab[strobe.drainIdx];
  assign cmplReg  = regTab[strobe.drainIdx][strobe.drainSlot];

  // R3: a block is never pending in two entries
  a_r3_unique_match: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(matchVec));
endmodule

// File: rtl/mshr_ctrl.sv
module mshr_ctrl
  import mshr_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   lookupValid,
  input  logic [NUM_ENTRIES-1:0] matchVec,
  input  logic                   memReqReady,
  input  logic                   fillValid,
  input  logic [IDX_W-1:0]       fillTag,
  output ctrlStrobe_t            strobe,
  output logic [NUM_ENTRIES-1:0] entryBusy,
  output logic                   lookupStall,
  output logic                   memReqValid,
  output logic                   fillReady,
  output logic                   cmplValid
);
  entState_t         st  [NUM_ENTRIES];
  logic [CNT_W-1:0]  cnt [NUM_ENTRIES];
  logic [IDX_W-1:0]  drainIdxQ, lockIdxQ;
  logic [SLOT_W-1:0] drainPtrQ;
  logic              lockQ;

  logic              anyMatch, anyFree, anyNeed, draining, matchFull;
  logic              accept, fillTake, lastOut;
  logic [IDX_W-1:0]  matchIdx, firstFree, firstNeed;

  always_comb begin
    anyMatch = 1'b0; anyFree = 1'b0; anyNeed = 1'b0; draining = 1'b0;
    matchIdx = '0; firstFree = '0; firstNeed = '0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (matchVec[i])         begin anyMatch = 1'b1; matchIdx  = IDX_W'(i); end
      if (st[i] == EntFree)    begin anyFree  = 1'b1; firstFree = IDX_W'(i); end
      if (st[i] == EntNeedReq) begin anyNeed  = 1'b1; firstNeed = IDX_W'(i); end
      if (st[i] == EntDrain)   draining = 1'b1;
    end
  end

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : gBusy
    assign entryBusy[g] = (st[g] != EntFree);
  end

  assign matchFull   = anyMatch && (cnt[matchIdx] == CNT_W'(NUM_TARGETS));
  assign lookupStall = lookupValid && (anyMatch ? matchFull : !anyFree);
  assign accept      = lookupValid && !lookupStall;
  assign memReqValid = anyNeed;
  assign fillReady   = !draining;
  assign fillTake    = fillValid && fillReady;
  assign cmplValid   = draining;

  always_comb begin
    strobe            = '0;
    strobe.alloc      = accept && !anyMatch;
    strobe.allocIdx   = firstFree;
    strobe.append     = accept && anyMatch;
    strobe.appendIdx  = matchIdx;
    strobe.appendSlot = cnt[matchIdx][SLOT_W-1:0];
    strobe.reqIdx     = lockQ ? lockIdxQ : firstNeed;
    strobe.drainIdx   = drainIdxQ;
    strobe.drainSlot  = drainPtrQ;
  end

  // last recorded target leaves and nothing joins in the same cycle
  assign lastOut = draining
                && ((CNT_W'(drainPtrQ) + CNT_W'(1)) == cnt[drainIdxQ])
                && !(strobe.append && (strobe.appendIdx == drainIdxQ));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_ENTRIES; i++) begin
        st[i]  <= EntFree;
        cnt[i] <= '0;
      end
      drainIdxQ <= '0;
      drainPtrQ <= '0;
      lockQ     <= 1'b0;
      lockIdxQ  <= '0;
    end else begin
      for (int i = 0; i < NUM_ENTRIES; i++) begin
        if (strobe.alloc && strobe.allocIdx == IDX_W'(i)) begin
          st[i]  <= EntNeedReq;
          cnt[i] <= CNT_W'(1);
        end
        if (strobe.append && strobe.appendIdx == IDX_W'(i))
          cnt[i] <= cnt[i] + CNT_W'(1);
        if (memReqValid && memReqReady && strobe.reqIdx == IDX_W'(i))
          st[i] <= EntWaitFill;
        if (fillTake && fillTag == IDX_W'(i))
          st[i] <= EntDrain;
        if (lastOut && drainIdxQ == IDX_W'(i))
          st[i] <= EntFree;
      end
      if (fillTake) begin
        drainIdxQ <= fillTag;
        drainPtrQ <= '0;
      end else if (draining && !lastOut) begin
        drainPtrQ <= drainPtrQ + SLOT_W'(1);
      end
      lockQ    <= memReqValid && !memReqReady;
      lockIdxQ <= strobe.reqIdx;
    end
  end

  a_r2_alloc_free_only: assert property (@(posedge clk) disable iff (!rstN)
    strobe.alloc |-> st[strobe.allocIdx] == EntFree);
  a_r2_alloc_requests: assert property (@(posedge clk) disable iff (!rstN)
    strobe.alloc |=> memReqValid);
  a_r3_append_busy: assert property (@(posedge clk) disable iff (!rstN)
    strobe.append |-> st[strobe.appendIdx] != EntFree);
  a_r6_req_hold: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=> (memReqValid && $stable(strobe.reqIdx)));
  a_r7_fill_waiting: assert property (@(posedge clk) disable iff (!rstN)
    fillTake |-> st[fillTag] == EntWaitFill);
  a_r7_fill_replays: assert property (@(posedge clk) disable iff (!rstN)
    fillTake |=> cmplValid);
  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : gChk
    a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
      cnt[g] <= CNT_W'(NUM_TARGETS));
  end
endmodule

// File: rtl/mshr_file.sv
module mshr_file
  import mshr_pkg::*;
#(
  parameter int unsigned ADDR_W = 26,
  parameter int unsigned LINE_W = 10,
  parameter int unsigned REG_W  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lookupValid,
  input  logic [ADDR_W-1:0] lookupAddr,
  input  logic [LINE_W-1:0] lookupLine,
  input  logic [REG_W-1:0]  lookupReg,
  output logic              lookupStall,
  output logic              memReqValid,
  input  logic              memReqReady,
  output logic [ADDR_W-1:0] memReqAddr,
  output logic [IDX_W-1:0]  memReqTag,
  input  logic              fillValid,
  output logic              fillReady,
  input  logic [IDX_W-1:0]  fillTag,
  output logic              cmplValid,
  output logic [IDX_W-1:0]  cmplTag,
  output logic [LINE_W-1:0] cmplLine,
  output logic [REG_W-1:0]  cmplReg
);
  ctrlStrobe_t            strobe;
  logic [NUM_ENTRIES-1:0] entryBusy, matchVec;

  mshr_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .lookupValid(lookupValid), .matchVec(matchVec),
    .memReqReady(memReqReady), .fillValid(fillValid), .fillTag(fillTag),
    .strobe(strobe), .entryBusy(entryBusy), .lookupStall(lookupStall),
    .memReqValid(memReqValid), .fillReady(fillReady), .cmplValid(cmplValid)
  );

  mshr_data #(.ADDR_W(ADDR_W), .LINE_W(LINE_W), .REG_W(REG_W)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .entryBusy(entryBusy),
    .lookupAddr(lookupAddr), .lookupLine(lookupLine), .lookupReg(lookupReg),
    .matchVec(matchVec), .reqAddr(memReqAddr), .cmplLine(cmplLine),
    .cmplReg(cmplReg)
  );

  assign memReqTag = strobe.reqIdx;
  assign cmplTag   = strobe.drainIdx;
endmodule

// File: tb/mshr_file_test.sv
module mshr_file_test;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 26, LINE_W = 10, REG_W = 6;
  localparam int BASE = 'h100;

  logic clk = 0, rstN = 0;
  logic lookupValid = 0, memReqReady = 0, fillValid = 0;
  logic [ADDR_W-1:0] lookupAddr = '0;
  logic [LINE_W-1:0] lookupLine = '0;
  logic [REG_W-1:0]  lookupReg = '0;
  logic [1:0]        fillTag = '0;
  logic lookupStall, memReqValid, fillReady, cmplValid;
  logic [ADDR_W-1:0] memReqAddr;
  logic [1:0]        memReqTag, cmplTag;
  logic [LINE_W-1:0] cmplLine;
  logic [REG_W-1:0]  cmplReg;

  int nChecks = 0, nFails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mshr_file #(.ADDR_W(ADDR_W), .LINE_W(LINE_W), .REG_W(REG_W)) uut (
    .clk(clk), .rstN(rstN), .lookupValid(lookupValid), .lookupAddr(lookupAddr),
    .lookupLine(lookupLine), .lookupReg(lookupReg), .lookupStall(lookupStall),
    .memReqValid(memReqValid), .memReqReady(memReqReady), .memReqAddr(memReqAddr),
    .memReqTag(memReqTag), .fillValid(fillValid), .fillReady(fillReady),
    .fillTag(fillTag), .cmplValid(cmplValid), .cmplTag(cmplTag),
    .cmplLine(cmplLine), .cmplReg(cmplReg)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic setLookup(int a, int l, int r);
    lookupValid = 1; lookupAddr = ADDR_W'(a);
    lookupLine = LINE_W'(l); lookupReg = REG_W'(r);
  endtask

  // fill one waiting entry and check its whole replay
  task automatic fillDrain(int tag, int n, int regBase, int line);
    fillValid = 1; fillTag = 2'(tag);
    #1 chk("R7 fillReady before fill", 32'(fillReady), 1);
    cyc(); fillValid = 0;
    for (int i = 0; i < n; i++) begin
      #1;
      chk("R7 cmplValid", 32'(cmplValid), 1);
      chk("R7 cmplTag", 32'(cmplTag), 32'(tag));
      chk("R7 cmplLine", 32'(cmplLine), 32'(line));
      chk("R7 cmplReg order", 32'(cmplReg), 32'(regBase + i));
      chk("R8 fillReady low in replay", 32'(fillReady), 0);
      cyc();
    end
    #1 chk("R7 replay ends", 32'(cmplValid), 0);
    chk("R8 fillReady back", 32'(fillReady), 1);
  endtask

  initial begin
    repeat (3) cyc();
    rstN = 1;
    #1;
    chk("R1 memReqValid", 32'(memReqValid), 0);
    chk("R1 cmplValid", 32'(cmplValid), 0);
    chk("R1 fillReady", 32'(fillReady), 1);
    chk("R1 lookupStall", 32'(lookupStall), 0);

    // primaries: entry e holds block BASE+e, line 10+e, first reg 4*e
    for (int e = 0; e < 4; e++) begin
      setLookup(BASE + e, 10 + e, 4 * e);
      #1 chk("R2 primary accepted", 32'(lookupStall), 0);
      cyc();
    end
    lookupValid = 0;
    #1;
    chk("R2 request valid", 32'(memReqValid), 1);
    chk("R2 request tag", 32'(memReqTag), 0);
    chk("R2 request addr", 32'(memReqAddr), BASE);

    // secondaries: entries 0..2 filled to 4 targets, entry 3 to 2
    for (int e = 0; e < 4; e++) begin
      for (int k = 1; k < ((e == 3) ? 2 : 4); k++) begin
        setLookup(BASE + e, 0, 4 * e + k);
        #1 chk("R10 R3 secondary accepted", 32'(lookupStall), 0);
        cyc();
      end
    end
    lookupValid = 0;
    #1 chk("R3 no new request tag", 32'(memReqTag), 0);

    setLookup(BASE, 0, 50);
    #1 chk("R5 targets full stall", 32'(lookupStall), 1);
    cyc();
    setLookup('h1FF, 0, 51);
    #1 chk("R4 entries full stall", 32'(lookupStall), 1);
    cyc();
    lookupValid = 0;

    // release requests: lowest index first, one per entry
    memReqReady = 1;
    for (int e = 0; e < 4; e++) begin
      #1;
      chk("R6 request valid", 32'(memReqValid), 1);
      chk("R6 request order", 32'(memReqTag), 32'(e));
      chk("R6 request addr", 32'(memReqAddr), 32'(BASE + e));
      cyc();
    end
    #1 chk("R6 R4 R3 no extra requests", 32'(memReqValid), 0);

    // out-of-order fill of entry 2, four targets (R5: no 5th target)
    fillDrain(2, 4, 8, 12);

    // entry 2 free again: new block becomes a primary there
    setLookup(BASE + 2, 30, 20);
    #1 chk("R7 reuse accepted", 32'(lookupStall), 0);
    cyc(); lookupValid = 0;
    #1;
    chk("R7 reuse request", 32'(memReqValid), 1);
    chk("R7 reuse tag", 32'(memReqTag), 2);
    chk("R7 reuse addr", 32'(memReqAddr), BASE + 2);
    cyc();
    #1 chk("R6 single request", 32'(memReqValid), 0);

    // fill of entry 3 coinciding with a matching lookup
    fillValid = 1; fillTag = 2'd3;
    setLookup(BASE + 3, 99, 40);
    #1;
    chk("R9 same-cycle accepted", 32'(lookupStall), 0);
    chk("R9 fill taken", 32'(fillReady), 1);
    cyc(); fillValid = 0; lookupValid = 0;
    #1 chk("R9 replay 0", 32'(cmplReg), 12);
    chk("R9 line from primary", 32'(cmplLine), 13);
    cyc();
    setLookup(BASE + 3, 0, 41);
    #1 chk("R9 replay 1", 32'(cmplReg), 13);
    chk("R9 mid-replay accepted", 32'(lookupStall), 0);
    cyc(); lookupValid = 0;
    #1 chk("R9 replay same-cycle target", 32'(cmplReg), 40);
    chk("R9 still valid", 32'(cmplValid), 1);
    cyc();
    #1 chk("R9 replay mid-replay target", 32'(cmplReg), 41);
    chk("R9 tag", 32'(cmplTag), 3);
    cyc();
    #1 chk("R9 freed after replay", 32'(cmplValid), 0);
    chk("R9 no request from appends", 32'(memReqValid), 0);

    fillDrain(0, 4, 0, 10);
    fillDrain(1, 4, 4, 11);
    fillDrain(2, 1, 20, 30);

    // all free: block BASE is primary again in entry 0
    memReqReady = 0;
    setLookup(BASE, 5, 1);
    #1 chk("R7 freed block primary", 32'(lookupStall), 0);
    cyc(); lookupValid = 0;
    #1 chk("R2 lowest free entry", 32'(memReqTag), 0);
    chk("R2 request after free", 32'(memReqValid), 1);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule